// File: doc/BRIEF.md
# Banked GPIO Output Latch and Direction Register File

This block is the register side of a general-purpose pin controller. Pins are grouped into banks of 32. Each bank has a read-only level register that returns the synchronized pad inputs. It also has a read/write direction register, and two write-only strobe registers. A 1 written to the strobe registers sets or clears individual output latch bits, so software never needs a read-modify-write to change one pin.

A plain word-wide register bus selects a bank and a register through an interleaved map. Three banks share each 256-byte page, and banks sit at 4-byte spacing inside each register group. Pad outputs and output enables come straight from flops. A compile-time mask can flip the direction sense of chosen pins, for pins whose enable is active-low at the pad. Read data is registered and appears one clock after the address.

Top module: `gpio_bank_regfile`

## Requirements
- R1: The pin count is a parameter. There are ceil(pins/32) banks. Bits of the last bank at or above the pin count read as 0 and can never be driven.
- R2: Bank n sits at byte offset ((n / 3) * 256) + ((n % 3) * 4). A bank index at or beyond the bank count is unmapped.
- R3: Inside a page, the groups are: level at 0x00, direction at 0x0C, set at 0x18 and clear at 0x24, each plus the bank's slot offset. Reads of the set and clear registers return 0.
- R4: Writing 1 to a set bit drives that pin's output latch to 1. Writing 1 to a clear bit drives it to 0. Bits written as 0 keep their value.
- R5: In any cycle with the write enable low, pad_out and pad_oe do not change.
- R6: The direction register reads back as written. pad_oe equals the direction bit for ordinary pins and its inverse for pins flagged in the inversion mask.
- R7: A level read returns each pad level two flops after the pad input. The value does not depend on direction. Read data is valid in the cycle after the address.
- R8: After reset, every pin is an input (pad_oe all 0), every output latch is 0 and read data is 0. For flagged pins the stored direction bit is 1.
- R9: An access is ignored on write and reads as 0 when its address is misaligned, has a within-page offset of 0x30 or more, or names a bank that does not exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | PIN_COUNT | Raw pad input levels |
| pad_out | output | PIN_COUNT | Output latch per pin |
| pad_oe | output | PIN_COUNT | Output enable per pin, 1 drives the pad |

## Verification
The bench builds the block with 121 pins. That gives four banks, with the last one only 25 pins wide and placed alone on the second page. This setting exercises the page arithmetic, the partial-bank masking and a nonexistent bank slot (0x104) together. Pins 86 to 89 are flagged in the inversion mask. The bench can then check the flipped enable sense and the reset value of a flagged direction bit inside a bank that also has ordinary pins.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  localparam int WORD_W      = 32;
  localparam int SLOTS_PAGE  = 3;
  localparam int GROUPS      = 4;

  typedef enum logic [1:0] {
    GRP_LEVEL = 2'd0,
    GRP_DIR   = 2'd1,
    GRP_SET   = 2'd2,
    GRP_CLR   = 2'd3
  } gpio_grp_e;

  // Mask of implemented pins in bank b of a controller with `pins` pins.
  function automatic logic [WORD_W-1:0] bank_valid(input int pins, input int b);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = ((b * WORD_W + i) < pins);
    return m;
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_rf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANKS  = 4,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output gpio_grp_e         grp,
  output logic [BANK_W-1:0] bank
);
  int unsigned word_idx;
  int unsigned page;
  int unsigned bnum;

  always_comb begin
    word_idx = int'(addr[7:2]);
    page     = int'(addr[ADDR_W-1:8]);
    bnum     = page * SLOTS_PAGE + (word_idx % SLOTS_PAGE);
    hit      = (addr[1:0] == 2'b00) && (word_idx < SLOTS_PAGE * GROUPS) &&
               (bnum < BANKS);
    grp      = gpio_grp_e'(2'(word_idx / SLOTS_PAGE));
    bank     = BANK_W'(bnum);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
  import gpio_rf_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID = '1,
  parameter logic [WORD_W-1:0] INV   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_dir,
  input  logic              we_set,
  input  logic              we_clr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] dir_q,
  output logic [WORD_W-1:0] lat_q,
  output logic [WORD_W-1:0] oe
);
  localparam logic [WORD_W-1:0] DIR_RST = INV & VALID;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RST;
      lat_q <= '0;
    end else begin
      if (we_dir) dir_q <= wdata & VALID;
      if (we_set) lat_q <= lat_q | (wdata & VALID);
      if (we_clr) lat_q <= lat_q & ~wdata;
    end
  end

  assign oe = (dir_q ^ INV) & VALID;
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_rf_pkg::*;
#(
  parameter int                   PIN_COUNT = 128,
  parameter int                   ADDR_W    = 12,
  parameter logic [PIN_COUNT-1:0] INV_MASK  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);
  localparam int BANKS  = (PIN_COUNT + WORD_W - 1) / WORD_W;
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int PADDED = BANKS * WORD_W;
  localparam logic [PADDED-1:0] INV_FULL = PADDED'(INV_MASK);

  logic              hit;
  gpio_grp_e         grp;
  logic [BANK_W-1:0] bank;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_dec (
    .addr(bus_addr), .hit(hit), .grp(grp), .bank(bank)
  );

  logic [PIN_COUNT-1:0] lvl_q;

  gpio_in_sync #(.W(PIN_COUNT)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(lvl_q)
  );

  logic [PADDED-1:0] lvl_full;
  logic [PADDED-1:0] dir_full;
  logic [PADDED-1:0] lat_full;
  logic [PADDED-1:0] oe_full;

  assign lvl_full = PADDED'(lvl_q);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [WORD_W-1:0] VMASK = bank_valid(PIN_COUNT, b);
    logic sel;
    assign sel = bus_we && hit && (bank == BANK_W'(b));

    gpio_bank_slice #(
      .VALID(VMASK),
      .INV  (INV_FULL[b*WORD_W +: WORD_W])
    ) u_slice (
      .clk   (clk),
      .rst   (rst),
      .we_dir(sel && (grp == GRP_DIR)),
      .we_set(sel && (grp == GRP_SET)),
      .we_clr(sel && (grp == GRP_CLR)),
      .wdata (bus_wdata),
      .dir_q (dir_full[b*WORD_W +: WORD_W]),
      .lat_q (lat_full[b*WORD_W +: WORD_W]),
      .oe    (oe_full[b*WORD_W +: WORD_W])
    );
  end

  assign pad_out = lat_full[PIN_COUNT-1:0];
  assign pad_oe  = oe_full[PIN_COUNT-1:0];

  logic [WORD_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (hit && (bank == BANK_W'(b))) begin
        case (grp)
          GRP_LEVEL: rd_next = lvl_full[b*WORD_W +: WORD_W];
          GRP_DIR:   rd_next = dir_full[b*WORD_W +: WORD_W];
          default:   rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_rf_checker.sv
module gpio_rf_checker #(
  parameter int PIN_COUNT = 128,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic                 wdata0,
  input logic [31:0]          bus_rdata,
  input logic [PIN_COUNT-1:0] pad_out,
  input logic [PIN_COUNT-1:0] pad_oe
);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(12'h024);

  p_set_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SET0 && wdata0) |=> pad_out[0]);

  p_clr_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CLR0 && wdata0) |=> !pad_out[0]);

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));

  p_strobe_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_SET0 || bus_addr == A_CLR0) |=> (bus_rdata == 32'h0));

  p_misaligned_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[1:0] != 2'b00) |=> (bus_rdata == 32'h0));

  p_past_page_end_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[7:0] >= 8'h30) |=> (bus_rdata == 32'h0));

  p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_out == '0 && pad_oe == '0 && bus_rdata == 32'h0));
endmodule

bind gpio_bank_regfile gpio_rf_checker #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .wdata0(bus_wdata[0]), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_bank_regfile_bench.sv
module gpio_bank_regfile_bench;
  localparam int NP = 121;
  localparam int AW = 12;
  localparam int NB = 4;
  localparam logic [NP-1:0] INV = NP'(4'hF) << 86;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  always #2 clk = ~clk;

  gpio_bank_regfile #(.PIN_COUNT(NP), .ADDR_W(AW), .INV_MASK(INV)) u_gpio_bank_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R8";

  // Behavioural reference model.
  logic [NP-1:0] m_dir, m_out, m_s1, m_s2;
  logic [31:0]   m_rd;

  function automatic void decode(input logic [AW-1:0] a, output bit ok,
                                 output int grp, output int bnk);
    int w, pg;
    w   = int'(a) % 256;
    pg  = int'(a) / 256;
    grp = w / 12;
    bnk = pg * 3 + (w % 12) / 4;
    ok  = (int'(a) % 4 == 0) && (w < 48) && (bnk < NB);
  endfunction

  always @(posedge clk) begin
    bit ok;
    int grp, bnk, p;
    logic [31:0] v;
    if (rst) begin
      m_dir = INV; m_out = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
    end else begin
      decode(bus_addr, ok, grp, bnk);
      v = '0;
      if (ok && (grp == 0 || grp == 1))
        for (int i = 0; i < 32; i++) begin
          p = bnk * 32 + i;
          if (p < NP) v[i] = (grp == 0) ? m_s2[p] : m_dir[p];
        end
      m_rd = v;
      if (bus_we && ok)
        for (int i = 0; i < 32; i++) begin
          p = bnk * 32 + i;
          if (p < NP) begin
            if (grp == 1) m_dir[p] = bus_wdata[i];
            if (grp == 2 && bus_wdata[i]) m_out[p] = 1'b1;
            if (grp == 3 && bus_wdata[i]) m_out[p] = 1'b0;
          end
        end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  task automatic chk(input string req, input bit ok, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_req, " pad_out R4"}, pad_out === m_out, 128'(pad_out), 128'(m_out));
      chk({cur_req, " pad_oe R6"}, pad_oe === (m_dir ^ INV), 128'(pad_oe), 128'(m_dir ^ INV));
      chk({cur_req, " rdata R7"}, bus_rdata === m_rd, 128'(bus_rdata), 128'(m_rd));
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    logic [NP-1:0] po, oe;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R8";
    chk("R8 reset oe", pad_oe == '0, 128'(pad_oe), 128'(0));
    chk("R8 reset out", pad_out == '0, 128'(pad_out), 128'(0));
    chk("R8 reset rdata", bus_rdata == 0, 128'(bus_rdata), 128'(0));
    rd(12'h014, r);
    chk("R8 flagged dir reset", r == 32'h03C0_0000, 128'(r), 128'(32'h03C0_0000));

    cur_req = "R6";
    wr(12'h00C, 32'hFFFF_0000);
    chk("R6 oe bank0", pad_oe[31:0] == 32'hFFFF_0000, 128'(pad_oe[31:0]), 128'(32'hFFFF_0000));
    rd(12'h00C, r);
    chk("R6 dir readback", r == 32'hFFFF_0000, 128'(r), 128'(32'hFFFF_0000));

    cur_req = "R4";
    wr(12'h018, 32'h0000_00F0);
    wr(12'h024, 32'h0000_0030);
    chk("R4 set then clear", pad_out[7:0] == 8'hC0, 128'(pad_out[7:0]), 128'(8'hC0));
    wr(12'h01C, 32'h8000_0001);
    chk("R4 bank1 set", pad_out[63:32] == 32'h8000_0001, 128'(pad_out[63:32]), 128'(32'h8000_0001));

    cur_req = "R3";
    rd(12'h018, r);
    chk("R3 set reads 0", r == 0, 128'(r), 128'(0));
    rd(12'h028, r);
    chk("R3 clear reads 0", r == 0, 128'(r), 128'(0));

    cur_req = "R1";
    wr(12'h10C, 32'hFFFF_FFFF);
    rd(12'h10C, r);
    chk("R1 R2 bank3 dir masked", r == 32'h01FF_FFFF, 128'(r), 128'(32'h01FF_FFFF));
    wr(12'h118, 32'hFFFF_FFFF);
    chk("R1 bank3 outputs", pad_out[120:96] == 25'h1FF_FFFF, 128'(pad_out[120:96]), 128'(25'h1FF_FFFF));

    cur_req = "R6";
    wr(12'h014, 32'h0);
    chk("R6 inverted pins drive", pad_oe[89:86] == 4'hF, 128'(pad_oe[89:86]), 128'(4'hF));
    chk("R6 plain pins bank2", pad_oe[85:64] == '0, 128'(pad_oe[85:64]), 128'(0));
    wr(12'h014, 32'h03C0_0001);
    chk("R6 inverted pins release", pad_oe[89:86] == 4'h0, 128'(pad_oe[89:86]), 128'(0));
    chk("R6 plain pin 64", pad_oe[64] == 1'b1, 128'(pad_oe[64]), 128'(1));

    cur_req = "R7";
    pad_in = {25'h0AB_CDEF, 32'h1234_5678, 32'hDEAD_BEEF, 32'hCAFE_F00D};
    repeat (3) @(negedge clk);
    rd(12'h000, r);
    chk("R7 level bank0 with outputs", r == 32'hCAFE_F00D, 128'(r), 128'(32'hCAFE_F00D));
    rd(12'h008, r);
    chk("R7 level bank2", r == 32'h1234_5678, 128'(r), 128'(32'h1234_5678));
    rd(12'h100, r);
    chk("R7 R2 level bank3", r == 32'h00AB_CDEF, 128'(r), 128'(32'h00AB_CDEF));
    pad_in = '0;
    @(negedge clk);
    rd(12'h004, r);
    chk("R7 two-flop latency", r == 32'hDEAD_BEEF, 128'(r), 128'(32'hDEAD_BEEF));

    cur_req = "R9";
    po = pad_out; oe = pad_oe;
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h01A, 32'hFFFF_FFFF);
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h11C, 32'hFFFF_FFFF);
    wr(12'h20C, 32'hFFFF_FFFF);
    chk("R9 writes ignored out", pad_out == po, 128'(pad_out), 128'(po));
    chk("R9 writes ignored oe", pad_oe == oe, 128'(pad_oe), 128'(oe));
    rd(12'h110, r);
    chk("R9 bank4 reads 0", r == 0, 128'(r), 128'(0));
    rd(12'h00D, r);
    chk("R9 misaligned reads 0", r == 0, 128'(r), 128'(0));
    rd(12'h034, r);
    chk("R9 past groups reads 0", r == 0, 128'(r), 128'(0));

    cur_req = "R5";
    po = pad_out; oe = pad_oe;
    bus_wdata = 32'hFFFF_FFFF;
    bus_addr = 12'h018;
    repeat (5) @(negedge clk);
    chk("R5 idle out stable", pad_out == po, 128'(pad_out), 128'(po));
    chk("R5 idle oe stable", pad_oe == oe, 128'(pad_oe), 128'(oe));

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule